// File: doc/BRIEF.md
# USB Host Receive Endpoint Control

This block keeps the control and status state of a single receive endpoint for a USB host controller. It sits next to a receive FIFO that holds up to two packets. It counts the packets that are buffered and turns that count into ready and full flags. It also keeps the data toggle, and it records three conditions: a STALL reply from the device, repeated attempts that return no data, and a NAK sequence that lasts too long.

Software reaches the block through a byte-wide status register. A write pulses `csr_wr` with a data byte. The current status is always present on `csr_rdata`. A separate protocol engine reports what happens on the bus: a data packet was stored, a STALL arrived, a NAK arrived, or an attempt timed out with no data. The FIFO side reports each packet unload together with its byte count. A frame tick drives the NAK timer. The block returns a one-cycle IN-request strobe and a one-cycle endpoint interrupt pulse.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00, `data_toggle` is 0, and `in_req` and `ep_irq` are low.
- R2: The status byte, from bit 7 down to bit 0, holds: toggle-clear (always reads 0), stalled, request-packet, flush (always reads 0), NAK-timeout, error, full, ready. Bits that software must clear are cleared by writing 0 to them. Writing 1 to one of those bits has no effect.
- R3: The block keeps a packet count from 0 to 2. Ready reads 1 whenever the count is nonzero, and full reads 1 when the count is 2. A packet that arrives while the count is 2 is ignored.
- R4: A write with bit 0 equal to 0 removes the oldest packet. A write with bit 0 equal to 1 leaves the count alone. When the count is already 0, such a write has no effect.
- R5: A write with bit 4 equal to 1 discards the oldest packet. Two such writes empty a FIFO that holds two packets.
- R6: When the auto-clear input is 1, an unload of exactly `cfg_max_pkt` bytes removes one packet. A shorter unload, or any unload while auto-clear is 0, leaves the count unchanged.
- R7: Writing 1 to bit 5 sets request-packet and raises `in_req` for one cycle after the write. Writing 0 to bit 5 clears request-packet. Any accepted packet clears request-packet.
- R8: `data_toggle` inverts on each accepted packet. A write with bit 7 equal to 1 clears `data_toggle`. A write with bit 7 equal to 0 leaves it unchanged.
- R9: `pe_stall` sets the stalled bit, and only a write of 0 to bit 6 clears it.
- R10: Endpoint type encoding: 0 = control, 1 = isochronous, 2 = bulk, 3 = interrupt. On bulk and interrupt endpoints, the third no-data attempt in a row sets the error bit. Any data packet restarts the attempt count. On the other endpoint types, no-data attempts are ignored.
- R11: On a bulk endpoint with a NAK limit L greater than 0, the NAK-timeout bit sets on the (L+1)-th frame tick after the first NAK. The timer starts from that first NAK, and any data packet restarts it. When L is 0, the timer is disabled. While NAK-timeout is set, request-packet is cleared, writes that set request-packet are ignored, and `in_req` stays low.
- R12: `ep_irq` pulses for one cycle after an accepted packet, a STALL, or an attempt that sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register contents |
| cfg_ep_type | input | 2 | Endpoint type (0 control, 1 iso, 2 bulk, 3 interrupt) |
| cfg_autoclr | input | 1 | Enable removal of a packet on a full-size unload |
| cfg_max_pkt | input | MAXP_W | Maximum packet size in bytes |
| cfg_nak_limit | input | NAK_W | NAK limit in frames, 0 disables the timer |
| pe_pkt_rx | input | 1 | Data packet stored in the FIFO |
| pe_stall | input | 1 | STALL handshake received |
| pe_nak | input | 1 | NAK handshake received |
| pe_no_data | input | 1 | Attempt ended without a data packet |
| unload_done | input | 1 | FIFO finished unloading a packet |
| unload_bytes | input | MAXP_W | Byte count of that unload |
| frame_tick | input | 1 | Start-of-frame tick |
| data_toggle | output | 1 | Expected data toggle for the next packet |
| in_req | output | 1 | One-cycle IN transaction request |
| ep_irq | output | 1 | One-cycle endpoint interrupt |

## Verification
The assertions assume that the protocol engine raises at most one event per cycle. They also assume that no software write lands in the same cycle as a packet arrival, so that arbitration between the two never decides a property. The bench keeps to these assumptions: every write and every event occupies its own cycle, and all other inputs are idle while it happens. The bench reaches full occupancy, overflow, flushes while two packets are buffered, unloads one byte short of the maximum, the reset of the attempt counter, and the halt of the NAK timer by a single ordered sequence of such cycles.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;
  typedef enum logic [1:0] {
    EPK_CTRL = 2'd0,
    EPK_ISO  = 2'd1,
    EPK_BULK = 2'd2,
    EPK_INTR = 2'd3
  } ep_kind_e;

  localparam int unsigned SB_CLRTGL = 7;
  localparam int unsigned SB_STALL  = 6;
  localparam int unsigned SB_REQ    = 5;
  localparam int unsigned SB_FLUSH  = 4;
  localparam int unsigned SB_NAKTO  = 3;
  localparam int unsigned SB_ERR    = 2;
  localparam int unsigned SB_FULL   = 1;
  localparam int unsigned SB_RDY    = 0;
endpackage

// File: rtl/rx_slot_tracker.sv
module rx_slot_tracker #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_req,
  input  logic pop_req,
  output logic accepted,
  output logic ready,
  output logic full
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic push, pop;

  always_comb begin
    push  = push_req && (cnt_q != LAST);
    pop   = pop_req && (cnt_q != '0);
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign accepted = push;
  assign ready    = (cnt_q != '0);
  assign full     = (cnt_q == LAST);
endmodule

// File: rtl/rx_retry_counter.sv
module rx_retry_counter #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic miss,
  input  logic hit,
  output logic exhausted
);
  localparam int unsigned AW = $clog2(LIMIT + 1);
  localparam logic [AW-1:0] TOP = AW'(LIMIT - 1);

  logic [AW-1:0] att_q, att_d;

  always_comb begin
    exhausted = enable && miss && !hit && (att_q == TOP);
    att_d     = att_q;
    if (hit)            att_d = '0;
    else if (exhausted) att_d = '0;
    else if (enable && miss) att_d = att_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) att_q <= '0;
    else        att_q <= att_d;
  end
endmodule

// File: rtl/rx_nak_timer.sv
module rx_nak_timer #(
  parameter int unsigned NAK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NAK_W-1:0] limit,
  input  logic             nak,
  input  logic             data,
  input  logic             tick,
  output logic             timeout
);
  logic             act_q, act_d;
  logic [NAK_W-1:0] frm_q, frm_d;

  always_comb begin
    act_d   = act_q;
    frm_d   = frm_q;
    timeout = 1'b0;
    if (!enable || data) begin
      act_d = 1'b0;
      frm_d = '0;
    end else if (act_q) begin
      if (tick) begin
        if (frm_q >= limit) begin
          timeout = 1'b1;
          act_d   = 1'b0;
          frm_d   = '0;
        end else begin
          frm_d = frm_q + 1'b1;
        end
      end
    end else if (nak) begin
      act_d = 1'b1;
      frm_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      frm_q <= '0;
    end else begin
      act_q <= act_d;
      frm_q <= frm_d;
    end
  end
endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rx_ep_pkg::*;
#(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned RETRY_LIMIT = 3,
  parameter int unsigned MAXP_W      = 11,
  parameter int unsigned NAK_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic [1:0]        cfg_ep_type,
  input  logic              cfg_autoclr,
  input  logic [MAXP_W-1:0] cfg_max_pkt,
  input  logic [NAK_W-1:0]  cfg_nak_limit,
  input  logic              pe_pkt_rx,
  input  logic              pe_stall,
  input  logic              pe_nak,
  input  logic              pe_no_data,
  input  logic              unload_done,
  input  logic [MAXP_W-1:0] unload_bytes,
  input  logic              frame_tick,
  output logic              data_toggle,
  output logic              in_req,
  output logic              ep_irq
);
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  ep_kind_e kind;
  assign kind = ep_kind_e'(cfg_ep_type);

  logic stall_q, stall_d;
  logic req_q, req_d;
  logic nakto_q, nakto_d;
  logic err_q, err_d;
  logic tgl_q, tgl_d;
  logic inreq_q, inreq_d;
  logic irq_q, irq_d;

  logic accepted, ready, full;
  logic pop_req, auto_pop, sw_pop;
  logic retry_en, exhausted;
  logic timer_en, timeout;

  assign sw_pop   = csr_wr && (csr_wdata[SB_FLUSH] || !csr_wdata[SB_RDY]);
  assign auto_pop = cfg_autoclr && unload_done && (unload_bytes == cfg_max_pkt);
  assign pop_req  = sw_pop || auto_pop;

  rx_slot_tracker #(.DEPTH(DEPTH)) u_slots (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push_req (pe_pkt_rx),
    .pop_req  (pop_req),
    .accepted (accepted),
    .ready    (ready),
    .full     (full)
  );

  assign retry_en = (kind == EPK_BULK) || (kind == EPK_INTR);

  rx_retry_counter #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .enable    (retry_en),
    .miss      (pe_no_data),
    .hit       (pe_pkt_rx),
    .exhausted (exhausted)
  );

  assign timer_en = (kind == EPK_BULK) && (cfg_nak_limit != '0) && !nakto_q;

  rx_nak_timer #(.NAK_W(NAK_W)) u_nak (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .enable  (timer_en),
    .limit   (cfg_nak_limit),
    .nak     (pe_nak),
    .data    (pe_pkt_rx),
    .tick    (frame_tick),
    .timeout (timeout)
  );

  always_comb begin
    stall_d = stall_q;
    req_d   = req_q;
    nakto_d = nakto_q;
    err_d   = err_q;
    tgl_d   = tgl_q;
    if (csr_wr) begin
      if (!csr_wdata[SB_STALL]) stall_d = 1'b0;
      if (!csr_wdata[SB_NAKTO]) nakto_d = 1'b0;
      if (!csr_wdata[SB_ERR])   err_d   = 1'b0;
      req_d = csr_wdata[SB_REQ] && !nakto_q;
    end
    if (pe_stall)  stall_d = 1'b1;
    if (exhausted) err_d   = 1'b1;
    if (timeout) begin
      nakto_d = 1'b1;
      req_d   = 1'b0;
    end
    if (accepted) begin
      req_d = 1'b0;
      tgl_d = !tgl_q;
    end
    if (csr_wr && csr_wdata[SB_CLRTGL]) tgl_d = 1'b0;
    inreq_d = csr_wr && csr_wdata[SB_REQ] && !nakto_q;
    irq_d   = accepted || pe_stall || exhausted;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      stall_q <= 1'b0;
      req_q   <= 1'b0;
      nakto_q <= 1'b0;
      err_q   <= 1'b0;
      tgl_q   <= 1'b0;
      inreq_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      stall_q <= stall_d;
      req_q   <= req_d;
      nakto_q <= nakto_d;
      err_q   <= err_d;
      tgl_q   <= tgl_d;
      inreq_q <= inreq_d;
      irq_q   <= irq_d;
    end
  end

  logic unused_wbit;
  assign unused_wbit = csr_wdata[SB_FULL];

  always_comb begin
    csr_rdata            = 8'h00;
    csr_rdata[SB_STALL]  = stall_q;
    csr_rdata[SB_REQ]    = req_q;
    csr_rdata[SB_NAKTO]  = nakto_q;
    csr_rdata[SB_ERR]    = err_q;
    csr_rdata[SB_FULL]   = full;
    csr_rdata[SB_RDY]    = ready;
  end

  assign data_toggle = tgl_q;
  assign in_req      = inreq_q;
  assign ep_irq      = irq_q;
endmodule

// File: rtl/usb_rx_ep_ctrl_chk.sv
module usb_rx_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csr_wr,
  input logic [7:0] csr_wdata,
  input logic [7:0] csr_rdata,
  input logic       pe_pkt_rx,
  input logic       pe_stall,
  input logic       pe_no_data,
  input logic       data_toggle,
  input logic       in_req,
  input logic       ep_irq
);
  AST_FULL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[1] |-> csr_rdata[0]); // R3

  AST_FLUSH_LEAVES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[1] && csr_wr && csr_wdata[4] && !pe_pkt_rx) |=> !csr_rdata[1]); // R5

  AST_PKT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_pkt_rx && !csr_rdata[1] && !csr_wr) |=> !csr_rdata[5]); // R7

  AST_CLRTGL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[7]) |=> !data_toggle); // R8

  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_pkt_rx && !csr_rdata[1] && !csr_wr) |=> (data_toggle != $past(data_toggle))); // R8

  AST_STALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pe_stall |=> csr_rdata[6]); // R9

  AST_HALT_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[3] |=> !in_req); // R11

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> $past(pe_pkt_rx || pe_stall || pe_no_data)); // R12
endmodule

bind usb_rx_ep_ctrl usb_rx_ep_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .csr_wr      (csr_wr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .pe_pkt_rx   (pe_pkt_rx),
  .pe_stall    (pe_stall),
  .pe_no_data  (pe_no_data),
  .data_toggle (data_toggle),
  .in_req      (in_req),
  .ep_irq      (ep_irq)
);

// File: tb/sim_usb_rx_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_rx_ep_ctrl;
  localparam int MAXP_W = 11;
  localparam int NAK_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              csr_wr;
  logic [7:0]        csr_wdata;
  logic [7:0]        csr_rdata;
  logic [1:0]        cfg_ep_type;
  logic              cfg_autoclr;
  logic [MAXP_W-1:0] cfg_max_pkt;
  logic [NAK_W-1:0]  cfg_nak_limit;
  logic              pe_pkt_rx, pe_stall, pe_nak, pe_no_data;
  logic              unload_done;
  logic [MAXP_W-1:0] unload_bytes;
  logic              frame_tick;
  logic              data_toggle, in_req, ep_irq;

  always #10 clk = ~clk;

  usb_rx_ep_ctrl #(.MAXP_W(MAXP_W), .NAK_W(NAK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .cfg_ep_type(cfg_ep_type), .cfg_autoclr(cfg_autoclr),
    .cfg_max_pkt(cfg_max_pkt), .cfg_nak_limit(cfg_nak_limit),
    .pe_pkt_rx(pe_pkt_rx), .pe_stall(pe_stall), .pe_nak(pe_nak),
    .pe_no_data(pe_no_data), .unload_done(unload_done),
    .unload_bytes(unload_bytes), .frame_tick(frame_tick),
    .data_toggle(data_toggle), .in_req(in_req), .ep_irq(ep_irq)
  );

  typedef struct {
    string      rid;
    logic [7:0] csr;
    logic       tgl;
    logic       irq;
    logic       req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  logic [7:0] e_csr;
  logic       e_tgl;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_checks++;
      if (csr_rdata !== it.csr || data_toggle !== it.tgl ||
          ep_irq !== it.irq || in_req !== it.req) begin
        n_errors++;
        $display("FAIL %s: got csr=%h tgl=%b irq=%b req=%b, expected csr=%h tgl=%b irq=%b req=%b",
                 it.rid, csr_rdata, data_toggle, ep_irq, in_req,
                 it.csr, it.tgl, it.irq, it.req);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_now(string rid, logic irq, logic req);
    exp_t it;
    it.rid = rid; it.csr = e_csr; it.tgl = e_tgl; it.irq = irq; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    step();
    csr_wr = 1'b0; csr_wdata = 8'h00;
  endtask

  task automatic pkt();
    pe_pkt_rx = 1'b1; step(); pe_pkt_rx = 1'b0;
  endtask

  task automatic nodata();
    pe_no_data = 1'b1; step(); pe_no_data = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1; step(); frame_tick = 1'b0;
  endtask

  task automatic unload(int nbytes);
    unload_done = 1'b1; unload_bytes = MAXP_W'(nbytes);
    step();
    unload_done = 1'b0; unload_bytes = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_wr = 1'b0; csr_wdata = 8'h00;
    cfg_ep_type = 2'd2; cfg_autoclr = 1'b0; cfg_max_pkt = 11'd64;
    cfg_nak_limit = '0; pe_pkt_rx = 1'b0; pe_stall = 1'b0; pe_nak = 1'b0;
    pe_no_data = 1'b0; unload_done = 1'b0; unload_bytes = '0; frame_tick = 1'b0;
    e_csr = 8'h00; e_tgl = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    expect_now("R1 reset state", 1'b0, 1'b0);

    // R7: request packet and strobe
    wr(8'h6D); e_csr = 8'h20; expect_now("R7 reqpkt set with strobe", 1'b0, 1'b1);
    step(); expect_now("R7 strobe lasts one cycle", 1'b0, 1'b0);

    // R3 R12 R8: fill both slots
    pkt(); e_csr = 8'h01; e_tgl = !e_tgl; expect_now("R3 R7 R12 first packet", 1'b1, 1'b0);
    pkt(); e_csr = 8'h03; e_tgl = !e_tgl; expect_now("R3 R8 second packet full", 1'b1, 1'b0);
    pkt(); expect_now("R3 packet ignored when full", 1'b0, 1'b0);

    // R5: flush twice
    wr(8'h5D); e_csr = 8'h01; expect_now("R5 first flush", 1'b0, 1'b0);
    wr(8'h5D); e_csr = 8'h00; expect_now("R5 second flush empties", 1'b0, 1'b0);

    // R8: toggle clear
    pkt(); e_csr = 8'h01; e_tgl = !e_tgl; expect_now("R8 toggle flips", 1'b1, 1'b0);
    wr(8'hCD); e_tgl = 1'b0; expect_now("R8 clear toggle", 1'b0, 1'b0);
    pkt(); e_csr = 8'h03; e_tgl = !e_tgl; expect_now("R8 toggle flips again", 1'b1, 1'b0);
    wr(8'h4D); expect_now("R2 R4 R8 writing ones changes nothing", 1'b0, 1'b0);

    // R4: software clear of ready
    wr(8'h4C); e_csr = 8'h01; expect_now("R4 clear pops one", 1'b0, 1'b0);
    wr(8'h4C); e_csr = 8'h00; expect_now("R4 clear pops last", 1'b0, 1'b0);
    wr(8'h4C); expect_now("R4 clear on empty", 1'b0, 1'b0);

    // R6: auto-clear
    cfg_autoclr = 1'b1;
    pkt(); e_csr = 8'h01; e_tgl = !e_tgl; expect_now("R6 packet in", 1'b1, 1'b0);
    unload(63); expect_now("R6 short unload keeps ready", 1'b0, 1'b0);
    unload(64); e_csr = 8'h00; expect_now("R6 full-size unload clears", 1'b0, 1'b0);
    cfg_autoclr = 1'b0;
    pkt(); e_csr = 8'h01; e_tgl = !e_tgl; expect_now("R6 packet in", 1'b1, 1'b0);
    unload(64); expect_now("R6 auto-clear disabled", 1'b0, 1'b0);
    wr(8'h4C); e_csr = 8'h00; expect_now("R4 manual clear", 1'b0, 1'b0);

    // R9: stall
    pe_stall = 1'b1; step(); pe_stall = 1'b0;
    e_csr = 8'h40; expect_now("R9 R12 stall sets", 1'b1, 1'b0);
    wr(8'h4D); expect_now("R2 R9 write one keeps stall", 1'b0, 1'b0);
    wr(8'h0D); e_csr = 8'h00; expect_now("R9 write zero clears stall", 1'b0, 1'b0);

    // R10: error after three misses
    nodata(); nodata(); expect_now("R10 two misses no error", 1'b0, 1'b0);
    pkt(); e_csr = 8'h01; e_tgl = !e_tgl; expect_now("R10 data packet", 1'b1, 1'b0);
    wr(8'h4C); e_csr = 8'h00;
    nodata(); nodata(); expect_now("R10 count restarted", 1'b0, 1'b0);
    nodata(); e_csr = 8'h04; expect_now("R10 R12 third miss sets error", 1'b1, 1'b0);
    wr(8'h49); e_csr = 8'h00; expect_now("R10 error cleared", 1'b0, 1'b0);
    nodata(); nodata(); pkt(); e_csr = 8'h01; e_tgl = !e_tgl;
    wr(8'h4C); e_csr = 8'h00;
    nodata(); expect_now("R10 data resets attempts", 1'b0, 1'b0);
    cfg_ep_type = 2'd1;
    nodata(); nodata(); nodata(); expect_now("R10 iso ignores misses", 1'b0, 1'b0);
    cfg_ep_type = 2'd2;

    // R11: NAK timeout with limit 3
    cfg_nak_limit = 5'd3;
    wr(8'h6D); e_csr = 8'h20; expect_now("R7 R11 request before NAKs", 1'b0, 1'b1);
    pe_nak = 1'b1; step(); pe_nak = 1'b0;
    tick(); tick(); tick(); expect_now("R11 no timeout at limit", 1'b0, 1'b0);
    tick(); e_csr = 8'h08; expect_now("R11 timeout halts", 1'b0, 1'b0);
    wr(8'h6D); expect_now("R11 request ignored while halted", 1'b0, 1'b0);
    wr(8'h45); e_csr = 8'h00; expect_now("R11 halt cleared", 1'b0, 1'b0);
    pe_nak = 1'b1; step(); pe_nak = 1'b0;
    tick(); tick();
    pkt(); e_csr = 8'h01; e_tgl = !e_tgl; expect_now("R11 data during NAKs", 1'b1, 1'b0);
    tick(); tick(); expect_now("R11 data restarts timer", 1'b0, 1'b0);
    wr(8'h4C); e_csr = 8'h00;
    cfg_nak_limit = '0;
    pe_nak = 1'b1; step(); pe_nak = 1'b0;
    repeat (6) tick();
    expect_now("R11 limit zero disables", 1'b0, 1'b0);

    repeat (3) step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule